// File: doc/BRIEF.md
# Banked UART Register Decoder

This block is the host-facing register front end of one 16550-style serial channel that carries a third, extended register bank. The host presents a 3-bit offset, an 8-bit write byte and separate read and write strobes. From the offset, the access direction and the current line control value, the block picks one physical register. It stores the control bytes, returns read data combinationally, and emits one-cycle strobes toward the transmit holding path, the receive buffer and the FIFO control logic. All of those sit outside this block.

The line control byte opens the banks. Its top bit exposes the two divisor bytes. The single value 0xBF also exposes the extended feature byte and four flow-control character bytes. The block also routes the serial lines. It applies internal loopback, and it holds the outgoing line at mark whenever the transmitter is idle.

Top module: `uart_regbank_dec`

## Requirements
- R1: After reset, the line control, interrupt enable, modem control and extended feature bytes all read as zero, and so do the divisor, scratch and four flow-character bytes.
- R2: When line control bit 7 is 0, offset 0 behaves as follows. A write pulses `thr_we` for the write cycle and changes no stored byte. A read returns `rx_byte` and pulses `rbr_re`.
- R3: When line control bit 7 is 1, offset 0 reads and writes the divisor low byte and offset 1 the divisor high byte. `thr_we` and `rbr_re` stay low, and the interrupt enable byte is untouched.
- R4: When line control is not 0xBF, offset 2 behaves as follows. A read returns `int_stat`. A write pulses `fcr_we` and changes no stored byte. When line control is 0xBF, offset 2 reads and writes the extended feature byte and `fcr_we` stays low.
- R5: Offset 3 reads and writes the line control byte whatever its current value.
- R6: When line control is exactly 0xBF, offsets 4, 5, 6 and 7 read and write XON-1, XON-2, XOFF-1 and XOFF-2, and the modem control and scratch bytes stay unchanged.
- R7: When line control is not 0xBF, offset 4 is modem control and offset 7 is scratch. Offset 5 reads `line_stat` and offset 6 reads `modem_stat`. Writes to offsets 5 and 6 change no stored byte.
- R8: The extended bank opens only on the exact value 0xBF. Any other value with bit 7 set, such as 0x80 or 0xBE, keeps offsets 2 and 4 to 7 in their normal meaning.
- R9: When modem control bit 4 is 1 (loopback), `tx_pin` is 1 and `rx_core` follows the transmitter output, ignoring `rx_pin`.
- R10: When `tx_active` is 0, the transmitter output is mark (1). This holds on `tx_pin`, and on `rx_core` while in loopback.
- R11: Outside loopback, `rx_core` equals `rx_pin`, and `tx_pin` equals `tx_core` while `tx_active` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 3 | Register offset |
| wdata | input | 8 | Host write byte |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| rdata | output | 8 | Read byte for the selected register |
| rx_byte | input | 8 | Head byte of the receive buffer |
| line_stat | input | 8 | Line status byte |
| modem_stat | input | 8 | Modem status byte |
| int_stat | input | 8 | Interrupt identification byte |
| thr_we | output | 1 | Transmit holding write pulse (data on `wdata`) |
| rbr_re | output | 1 | Receive buffer read pulse |
| fcr_we | output | 1 | FIFO control write pulse (data on `wdata`) |
| lcr_o | output | 8 | Line control byte |
| ier_o | output | 8 | Interrupt enable byte |
| mcr_o | output | 8 | Modem control byte |
| dll_o | output | 8 | Divisor low byte |
| dlm_o | output | 8 | Divisor high byte |
| efr_o | output | 8 | Extended feature byte |
| xon1_o | output | 8 | XON-1 byte |
| xon2_o | output | 8 | XON-2 byte |
| xoff1_o | output | 8 | XOFF-1 byte |
| xoff2_o | output | 8 | XOFF-2 byte |
| tx_core | input | 1 | Transmit shifter output |
| tx_active | input | 1 | Transmitter busy |
| rx_pin | input | 1 | External receive line |
| tx_pin | output | 1 | External transmit line |
| rx_core | output | 1 | Receive line fed to the receiver |

## Verification
A mis-decoded bank shows up as a write that lands in the aliased register. That register is exported, so the error is visible on its output port one clock after the write edge, long before any read-back. Strobe errors, such as a spurious `thr_we` or `rbr_re` under an open divisor bank, appear in the same cycle as the access. Loopback and idle-level faults appear combinationally on `tx_pin` and `rx_core` as soon as modem control bit 4 or `tx_active` changes.

// File: rtl/uart_regbank_dec.sv
module uart_regbank_dec #(
  parameter int              DW       = 8,
  parameter logic [DW-1:0]   EXT_KEY  = 8'hBF,
  parameter int              LOOP_BIT = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [2:0]    addr,
  input  logic [DW-1:0] wdata,
  input  logic          wr_en,
  input  logic          rd_en,
  output logic [DW-1:0] rdata,
  input  logic [DW-1:0] rx_byte,
  input  logic [DW-1:0] line_stat,
  input  logic [DW-1:0] modem_stat,
  input  logic [DW-1:0] int_stat,
  output logic          thr_we,
  output logic          rbr_re,
  output logic          fcr_we,
  output logic [DW-1:0] lcr_o,
  output logic [DW-1:0] ier_o,
  output logic [DW-1:0] mcr_o,
  output logic [DW-1:0] dll_o,
  output logic [DW-1:0] dlm_o,
  output logic [DW-1:0] efr_o,
  output logic [DW-1:0] xon1_o,
  output logic [DW-1:0] xon2_o,
  output logic [DW-1:0] xoff1_o,
  output logic [DW-1:0] xoff2_o,
  input  logic          tx_core,
  input  logic          tx_active,
  input  logic          rx_pin,
  output logic          tx_pin,
  output logic          rx_core
);

  logic [DW-1:0] scr_q;
  logic          div_open, ext_open, loop_on, tx_line;

  assign div_open = lcr_o[DW-1];
  assign ext_open = (lcr_o == EXT_KEY);
  assign loop_on  = mcr_o[LOOP_BIT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lcr_o   <= '0;
      ier_o   <= '0;
      mcr_o   <= '0;
      dll_o   <= '0;
      dlm_o   <= '0;
      efr_o   <= '0;
      xon1_o  <= '0;
      xon2_o  <= '0;
      xoff1_o <= '0;
      xoff2_o <= '0;
      scr_q   <= '0;
    end else if (wr_en) begin
      case (addr)
        3'd0: if (div_open) dll_o <= wdata;
        3'd1: if (div_open) dlm_o <= wdata; else ier_o <= wdata;
        3'd2: if (ext_open) efr_o <= wdata;
        3'd3: lcr_o <= wdata;
        3'd4: if (ext_open) xon1_o <= wdata; else mcr_o <= wdata;
        3'd5: if (ext_open) xon2_o <= wdata;
        3'd6: if (ext_open) xoff1_o <= wdata;
        default: if (ext_open) xoff2_o <= wdata; else scr_q <= wdata;
      endcase
    end
  end

  always_comb begin
    case (addr)
      3'd0:    rdata = div_open ? dll_o : rx_byte;
      3'd1:    rdata = div_open ? dlm_o : ier_o;
      3'd2:    rdata = ext_open ? efr_o : int_stat;
      3'd3:    rdata = lcr_o;
      3'd4:    rdata = ext_open ? xon1_o : mcr_o;
      3'd5:    rdata = ext_open ? xon2_o : line_stat;
      3'd6:    rdata = ext_open ? xoff1_o : modem_stat;
      default: rdata = ext_open ? xoff2_o : scr_q;
    endcase
  end

  assign thr_we = wr_en && addr == 3'd0 && !div_open;
  assign rbr_re = rd_en && addr == 3'd0 && !div_open;
  assign fcr_we = wr_en && addr == 3'd2 && !ext_open;

  assign tx_line = tx_active ? tx_core : 1'b1;
  assign tx_pin  = loop_on ? 1'b1 : tx_line;
  assign rx_core = loop_on ? tx_line : rx_pin;

  AST_LCR_ANY_BANK: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && addr == 3'd3 |=> lcr_o == $past(wdata)); // R5
  AST_DIV_KEEPS_IER: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && div_open && addr == 3'd1 |=> $stable(ier_o)); // R3
  AST_EXT_KEEPS_MCR: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && ext_open && addr[2] |=> $stable(mcr_o) && $stable(scr_q)); // R6
  AST_RO_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && !ext_open && (addr == 3'd5 || addr == 3'd6) |=> $stable(xon2_o) && $stable(xoff1_o)); // R7
  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({thr_we, fcr_we, rbr_re})); // R2
  AST_LOOP_MARK: assert property (@(posedge clk) disable iff (!rst_n)
    loop_on |-> tx_pin); // R9
  AST_IDLE_MARK: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_active |-> tx_pin && (rx_core || !loop_on)); // R10

endmodule

// File: tb/uart_regbank_dec_tb.sv
module uart_regbank_dec_tb;
  logic clk = 0, rst_n = 0;
  logic [2:0] addr = 0;
  logic [7:0] wdata = 0, rx_byte = 0, line_stat = 0, modem_stat = 0, int_stat = 0;
  logic wr_en = 0, rd_en = 0, tx_core = 1, tx_active = 0, rx_pin = 1;
  logic [7:0] rdata, lcr_o, ier_o, mcr_o, dll_o, dlm_o, efr_o, xon1_o, xon2_o, xoff1_o, xoff2_o;
  logic thr_we, rbr_re, fcr_we, tx_pin, rx_core;

  int vectors = 0, errors = 0;
  logic [7:0] m_lcr, m_ier, m_mcr, m_dll, m_dlm, m_efr, m_scr, m_x1, m_x2, m_f1, m_f2;

  always #10 clk = ~clk;

  uart_regbank_dec u_dut (.*);

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_rd(input logic [2:0] a);
    logic ext = (m_lcr == 8'hBF);
    logic dv  = m_lcr[7];
    case (a)
      3'd0: return dv ? m_dll : rx_byte;
      3'd1: return dv ? m_dlm : m_ier;
      3'd2: return ext ? m_efr : int_stat;
      3'd3: return m_lcr;
      3'd4: return ext ? m_x1 : m_mcr;
      3'd5: return ext ? m_x2 : line_stat;
      3'd6: return ext ? m_f1 : modem_stat;
      default: return ext ? m_f2 : m_scr;
    endcase
  endfunction

  task automatic model_wr(input logic [2:0] a, input logic [7:0] d);
    logic ext = (m_lcr == 8'hBF);
    logic dv  = m_lcr[7];
    case (a)
      3'd0: if (dv) m_dll = d;
      3'd1: if (dv) m_dlm = d; else m_ier = d;
      3'd2: if (ext) m_efr = d;
      3'd3: m_lcr = d;
      3'd4: if (ext) m_x1 = d; else m_mcr = d;
      3'd5: if (ext) m_x2 = d;
      3'd6: if (ext) m_f1 = d;
      default: if (ext) m_f2 = d; else m_scr = d;
    endcase
  endtask

  task automatic chk_regs(input string req);
    chk({req, " lcr"}, lcr_o, m_lcr);
    chk({req, " ier"}, ier_o, m_ier);
    chk({req, " mcr"}, mcr_o, m_mcr);
    chk({req, " dll"}, dll_o, m_dll);
    chk({req, " dlm"}, dlm_o, m_dlm);
    chk({req, " efr"}, efr_o, m_efr);
    chk({req, " xon1"}, xon1_o, m_x1);
    chk({req, " xon2"}, xon2_o, m_x2);
    chk({req, " xoff1"}, xoff1_o, m_f1);
    chk({req, " xoff2"}, xoff2_o, m_f2);
  endtask

  task automatic chk_pins();
    logic line = tx_active ? tx_core : 1'b1;
    if (m_mcr[4]) begin
      chk("R9 tx_pin loop", {7'd0, tx_pin}, 8'd1);
      chk("R9/R10 rx_core loop", {7'd0, rx_core}, {7'd0, line});
    end else begin
      chk("R10/R11 tx_pin", {7'd0, tx_pin}, {7'd0, line});
      chk("R11 rx_core", {7'd0, rx_core}, {7'd0, rx_pin});
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1;
    #2;
    chk("R2 thr_we", {7'd0, thr_we}, {7'd0, a == 3'd0 && !m_lcr[7]});
    chk("R4 fcr_we", {7'd0, fcr_we}, {7'd0, a == 3'd2 && m_lcr != 8'hBF});
    model_wr(a, d);
    @(negedge clk);
    wr_en = 0;
    #2;
    chk_regs("R3/R6/R7/R8 bank write");
  endtask

  task automatic rd(input logic [2:0] a);
    @(negedge clk);
    addr = a; rd_en = 1;
    #2;
    chk("R2-R8 rdata", rdata, exp_rd(a));
    chk("R2/R3 rbr_re", {7'd0, rbr_re}, {7'd0, a == 3'd0 && !m_lcr[7]});
    chk("R3 thr_we on read", {7'd0, thr_we}, 8'd0);
    @(negedge clk);
    rd_en = 0;
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    {m_lcr, m_ier, m_mcr, m_dll, m_dlm, m_efr, m_scr, m_x1, m_x2, m_f1, m_f2} = '0;
    rx_byte = 8'h3C; line_stat = 8'h60; modem_stat = 8'hB0; int_stat = 8'hC1;
    #45 rst_n = 1;
    @(negedge clk);
    chk_regs("R1 reset");
    for (int i = 0; i < 8; i++) rd(3'(i));
    // R2: THR write, RBR read
    wr(3'd0, 8'hA5); rd(3'd0);
    // R3: divisor bank
    wr(3'd1, 8'h0F);
    wr(3'd3, 8'h83); wr(3'd0, 8'h12); wr(3'd1, 8'h34); rd(3'd0); rd(3'd1);
    // R8: 0xBE is not the key
    wr(3'd3, 8'hBE); wr(3'd4, 8'h09); wr(3'd2, 8'h77); wr(3'd5, 8'h55); wr(3'd7, 8'h66); rd(3'd4);
    // R6/R4: extended bank
    wr(3'd3, 8'hBF);
    for (int i = 4; i < 8; i++) wr(3'(i), 8'hE0 + 8'(i));
    wr(3'd2, 8'hD0); rd(3'd2); rd(3'd7); rd(3'd3);
    // R5: leave via offset 3, R7 read-only status
    wr(3'd3, 8'h03); wr(3'd6, 8'h99); rd(3'd5); rd(3'd6); rd(3'd7);
    // R9/R10/R11: pin paths
    for (int lp = 0; lp < 2; lp++) begin
      wr(3'd4, lp ? 8'h10 : 8'h00);
      for (int k = 0; k < 8; k++) begin
        @(negedge clk);
        {tx_active, tx_core, rx_pin} = 3'(k);
        #2 chk_pins();
      end
    end
    // random mix
    for (int n = 0; n < 600; n++) begin
      int sel = $urandom_range(0, 9);
      rx_byte = 8'($urandom); line_stat = 8'($urandom);
      modem_stat = 8'($urandom); int_stat = 8'($urandom);
      {tx_active, tx_core, rx_pin} = 3'($urandom);
      if (sel == 0) begin
        case ($urandom_range(0, 4))
          0: wr(3'd3, 8'h00);
          1: wr(3'd3, 8'h80);
          2: wr(3'd3, 8'hBF);
          3: wr(3'd3, 8'hBE);
          default: wr(3'd3, 8'($urandom));
        endcase
      end else if (sel < 5) wr(3'($urandom), 8'($urandom));
      else rd(3'($urandom));
      #1 chk_pins();
    end
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule